// File: doc/BRIEF.md
# Processor Status Flags and Maskable Interrupt Gate

This block holds the 11-bit status word of a small processor core. The word carries the arithmetic result flags (carry, zero, sign, overflow), a debug flag that is always held at zero, the register-bank select, the interrupt enable, the stack select and a 3-bit interrupt level. The execution stage updates any subset of the four result flags in one cycle, each flag with its own enable. A separate port loads the whole word at once.

The block also decides whether a maskable interrupt request is taken. A request is accepted only when interrupts are enabled and the request priority is strictly higher than the stored level. When the core acknowledges a hardware interrupt, the block clears the enable flag and the stack select flag. A software interrupt also clears the enable flag, but it clears the stack select flag only for low vector numbers. The bank and stack select bits are brought out as separate pins for the register file and the stack-pointer mux.

Top module: `flag_reg_irq`

## Requirements
- R1: Reset drives the whole word to zero, so bank 0 and the interrupt stack are selected and interrupts are disabled. The word stays zero for the two cycles after reset is released.
- R2: On a clock with `alu_upd[k]` set, the flag picked by k (0=carry at bit 0, 1=zero at bit 2, 2=sign at bit 3, 3=overflow at bit 5) takes `alu_flags[k]`. Flags whose enable is clear keep their value.
- R3: A write with `wr_en` loads `wr_data` into the word on the next clock, except bit 1 (debug), which always reads 0.
- R4: When `wr_en` and any `alu_upd` bit are set on the same clock, the written value wins for every flag.
- R5: `irq_accept` is high in the same cycle exactly when `irq_req` is 1, the enable flag (bit 6) is 1, and `irq_prio` is strictly greater than the level field (bits 10:8).
- R6: `hw_ack` clears the enable flag (bit 6) and the stack select flag (bit 7) on the next clock.
- R7: `sw_ack` clears bit 6. It also clears bit 7 when `sw_vec` is below 32, and leaves bit 7 unchanged when `sw_vec` is 32 or above.
- R8: The clears caused by an acknowledge override a whole-word write on the same clock. All other bits still take the written value.
- R9: `bank_sel` always equals bit 4 of the word and `stk_sel` always equals bit 7.
- R10: On a clock with no write, no flag enable and no acknowledge, the word is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| alu_flags | input | 4 | Result status: bit0 carry, bit1 zero, bit2 sign, bit3 overflow |
| alu_upd | input | 4 | Per-flag update enables, same order as `alu_flags` |
| wr_en | input | 1 | Whole-word write strobe |
| wr_data | input | 11 | Value for the whole-word write |
| irq_req | input | 1 | Maskable interrupt request |
| irq_prio | input | 3 | Priority of the request |
| hw_ack | input | 1 | Hardware interrupt acknowledge strobe |
| sw_ack | input | 1 | Software interrupt strobe |
| sw_vec | input | 6 | Software interrupt number |
| psr_q | output | 11 | Current status word |
| bank_sel | output | 1 | Register bank select (bit 4) |
| stk_sel | output | 1 | Stack select: 0 interrupt stack, 1 user stack (bit 7) |
| irq_accept | output | 1 | Request accepted under the current word |

## Verification
Every change to the status word (flag updates, writes, acknowledge clears) shows on `psr_q`, `bank_sel` and `stk_sel` one clock after the inputs that caused it. `irq_accept` is combinational from the stored word and the request inputs, so it is valid in the same cycle. The bench changes inputs just after a rising edge. It compares `irq_accept` at the falling edge, before the register moves. It then advances its own model at the rising edge and compares the word and select pins one nanosecond later. Right after reset is released, the internal reset synchronizer adds two more cycles of zero output, and the model is checked over that window.

// File: rtl/flag_reg_irq_pkg.sv
package flag_reg_irq_pkg;
  localparam int PSR_W   = 11;
  localparam int LVL_W   = 3;
  localparam int ALU_N   = 4;
  localparam int POS_C   = 0;
  localparam int POS_D   = 1;
  localparam int POS_Z   = 2;
  localparam int POS_S   = 3;
  localparam int POS_B   = 4;
  localparam int POS_O   = 5;
  localparam int POS_I   = 6;
  localparam int POS_U   = 7;
  localparam int POS_LVL = 8;

  typedef logic [PSR_W-1:0] psr_t;

  // Map a word bit to the index of the result flag that drives it, or -1.
  function automatic int alu_idx(int bitpos);
    case (bitpos)
      POS_C:   return 0;
      POS_Z:   return 1;
      POS_S:   return 2;
      POS_O:   return 3;
      default: return -1;
    endcase
  endfunction
endpackage

// File: rtl/flag_reg_irq_rst_sync.sv
module flag_reg_irq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/flag_reg_irq_next.sv
module flag_reg_irq_next
  import flag_reg_irq_pkg::*;
#(
  parameter int VEC_W      = 6,
  parameter int SW_U_LIMIT = 32
) (
  input  psr_t             cur,
  input  logic [ALU_N-1:0] alu_flags,
  input  logic [ALU_N-1:0] alu_upd,
  input  logic             wr_en,
  input  psr_t             wr_data,
  input  logic             hw_ack,
  input  logic             sw_ack,
  input  logic [VEC_W-1:0] sw_vec,
  output psr_t             nxt,
  output logic             load
);
  localparam int CMP_W = VEC_W + 1;

  psr_t alu_img;
  logic sw_low;
  logic clr_u;

  // Per-bit selection between the stored value and a result flag.
  for (genvar i = 0; i < PSR_W; i++) begin : g_bit
    localparam int K = alu_idx(i);
    if (K >= 0) begin : g_alu
      assign alu_img[i] = alu_upd[K] ? alu_flags[K] : cur[i];
    end else begin : g_keep
      assign alu_img[i] = cur[i];
    end
  end

  assign sw_low = ({1'b0, sw_vec} < CMP_W'(SW_U_LIMIT));
  assign clr_u  = hw_ack | (sw_ack & sw_low);
  assign load   = wr_en | (|alu_upd) | hw_ack | sw_ack;

  always_comb begin
    nxt = wr_en ? wr_data : alu_img;
    nxt[POS_D] = 1'b0;
    if (hw_ack || sw_ack) nxt[POS_I] = 1'b0;
    if (clr_u)            nxt[POS_U] = 1'b0;
  end
endmodule

// File: rtl/flag_reg_irq_accept.sv
module flag_reg_irq_accept #(
  parameter int PRIO_W = 3,
  parameter int LVL_W  = 3
) (
  input  logic              irq_req,
  input  logic [PRIO_W-1:0] irq_prio,
  input  logic              ien,
  input  logic [LVL_W-1:0]  level,
  output logic              accept
);
  localparam int CW = (PRIO_W > LVL_W) ? PRIO_W : LVL_W;

  logic [CW-1:0] prio_x;
  logic [CW-1:0] lvl_x;

  assign prio_x = CW'(irq_prio);
  assign lvl_x  = CW'(level);
  assign accept = irq_req & ien & (prio_x > lvl_x);
endmodule

// File: rtl/flag_reg_irq.sv
module flag_reg_irq
  import flag_reg_irq_pkg::*;
#(
  parameter int PRIO_W     = 3,
  parameter int VEC_W      = 6,
  parameter int SW_U_LIMIT = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        alu_flags,
  input  logic [3:0]        alu_upd,
  input  logic              wr_en,
  input  logic [10:0]       wr_data,
  input  logic              irq_req,
  input  logic [PRIO_W-1:0] irq_prio,
  input  logic              hw_ack,
  input  logic              sw_ack,
  input  logic [VEC_W-1:0]  sw_vec,
  output logic [10:0]       psr_q,
  output logic              bank_sel,
  output logic              stk_sel,
  output logic              irq_accept
);
  logic rst_sync_n;
  psr_t psr_r;
  psr_t psr_nxt;
  logic psr_load;

  flag_reg_irq_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  flag_reg_irq_next #(
    .VEC_W      (VEC_W),
    .SW_U_LIMIT (SW_U_LIMIT)
  ) u_next (
    .cur       (psr_r),
    .alu_flags (alu_flags),
    .alu_upd   (alu_upd),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .hw_ack    (hw_ack),
    .sw_ack    (sw_ack),
    .sw_vec    (sw_vec),
    .nxt       (psr_nxt),
    .load      (psr_load)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)   psr_r <= '0;
    else if (psr_load) psr_r <= psr_nxt;
  end

  flag_reg_irq_accept #(
    .PRIO_W (PRIO_W),
    .LVL_W  (LVL_W)
  ) u_acc (
    .irq_req  (irq_req),
    .irq_prio (irq_prio),
    .ien      (psr_r[POS_I]),
    .level    (psr_r[POS_LVL +: LVL_W]),
    .accept   (irq_accept)
  );

  assign psr_q    = psr_r;
  assign bank_sel = psr_r[POS_B];
  assign stk_sel  = psr_r[POS_U];
endmodule

// File: rtl/flag_reg_irq_chk.sv
module flag_reg_irq_chk #(
  parameter int PRIO_W     = 3,
  parameter int VEC_W      = 6,
  parameter int SW_U_LIMIT = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [3:0]        alu_upd,
  input logic              wr_en,
  input logic              irq_req,
  input logic [PRIO_W-1:0] irq_prio,
  input logic              hw_ack,
  input logic              sw_ack,
  input logic [VEC_W-1:0]  sw_vec,
  input logic [10:0]       psr_q,
  input logic              irq_accept
);
  a_r3_debug_zero: assert property (@(posedge clk) disable iff (!rst_n)
    psr_q[1] == 1'b0);

  a_r5_accept_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    irq_accept |-> psr_q[6]);

  a_r5_accept_above_level: assert property (@(posedge clk) disable iff (!rst_n)
    irq_accept |-> (32'(irq_prio) > 32'(psr_q[10:8])) && irq_req);

  a_r6_hw_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    hw_ack |=> (psr_q[6] == 1'b0) && (psr_q[7] == 1'b0));

  a_r7_high_vec_keeps_u: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_ack && !hw_ack && !wr_en && (32'(sw_vec) >= SW_U_LIMIT))
      |=> psr_q[7] == $past(psr_q[7]));

  a_r7_sw_ack_clears_i: assert property (@(posedge clk) disable iff (!rst_n)
    sw_ack |=> psr_q[6] == 1'b0);

  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && (alu_upd == 4'b0000) && !hw_ack && !sw_ack) |=> $stable(psr_q));
endmodule

bind flag_reg_irq flag_reg_irq_chk #(
  .PRIO_W     (PRIO_W),
  .VEC_W      (VEC_W),
  .SW_U_LIMIT (SW_U_LIMIT)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .alu_upd    (alu_upd),
  .wr_en      (wr_en),
  .irq_req    (irq_req),
  .irq_prio   (irq_prio),
  .hw_ack     (hw_ack),
  .sw_ack     (sw_ack),
  .sw_vec     (sw_vec),
  .psr_q      (psr_q),
  .irq_accept (irq_accept)
);

// File: tb/flag_reg_irq_tb.sv
`timescale 1ns/1ps
module flag_reg_irq_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  alu_flags, alu_upd;
  logic        wr_en;
  logic [10:0] wr_data;
  logic        irq_req;
  logic [2:0]  irq_prio;
  logic        hw_ack, sw_ack;
  logic [5:0]  sw_vec;
  logic [10:0] psr_q;
  logic        bank_sel, stk_sel, irq_accept;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  logic [10:0] model = '0;

  always #2.5 clk = ~clk;

  flag_reg_irq u_dut (
    .clk(clk), .rst_n(rst_n), .alu_flags(alu_flags), .alu_upd(alu_upd),
    .wr_en(wr_en), .wr_data(wr_data), .irq_req(irq_req), .irq_prio(irq_prio),
    .hw_ack(hw_ack), .sw_ack(sw_ack), .sw_vec(sw_vec),
    .psr_q(psr_q), .bank_sel(bank_sel), .stk_sel(stk_sel), .irq_accept(irq_accept)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      total++; bad++;
      $display("FAIL R10 watchdog: actual=%0d cycles expected<=20000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(string tag, int got, int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, got, exp);
    end
  endtask

  task automatic set_in(bit w, int wd, int fl, int up, bit hw, bit sw, int vec,
                        bit req, int prio);
    wr_en = w; wr_data = 11'(wd); alu_flags = 4'(fl); alu_upd = 4'(up);
    hw_ack = hw; sw_ack = sw; sw_vec = 6'(vec); irq_req = req; irq_prio = 3'(prio);
  endtask

  task automatic idle();
    set_in(0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  // Behavioural reference: one clock of the status word.
  task automatic model_step();
    logic [10:0] n;
    int pos [4];
    pos = '{0, 2, 3, 5};
    n = model;
    if (wr_en) n = wr_data;
    else for (int k = 0; k < 4; k++) if (alu_upd[k]) n[pos[k]] = alu_flags[k];
    n[1] = 1'b0;
    if (hw_ack || sw_ack) n[6] = 1'b0;
    if (hw_ack || (sw_ack && int'(sw_vec) < 32)) n[7] = 1'b0;
    model = n;
  endtask

  task automatic run(string tag);
    int exp_acc;
    @(negedge clk);
    exp_acc = (irq_req && model[6] && int'(irq_prio) > int'(model[10:8])) ? 1 : 0;
    check({tag, " accept"}, int'(irq_accept), exp_acc);
    @(posedge clk);
    if (rst_n) model_step();
    #1;
    check({tag, " word"}, int'(psr_q), int'(model));
    check("R9 bank_sel", int'(bank_sel), int'(model[4]));
    check("R9 stk_sel", int'(stk_sel), int'(model[7]));
  endtask

  initial begin
    rst_n = 1'b0;
    idle();
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset word", int'(psr_q), 0);
    check("R1 reset stk_sel", int'(stk_sel), 0);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: zero through the synchronizer window.
    for (int i = 0; i < 3; i++) run("R1");

    // R3: full write, debug bit forced to zero.
    set_in(1, 'h7FF, 0, 0, 0, 0, 0, 0, 0); run("R3");
    // R2: flag updates, different enable patterns.
    set_in(0, 0, 'b0000, 'b1111, 0, 0, 0, 0, 0); run("R2");
    set_in(0, 0, 'b1111, 'b0101, 0, 0, 0, 0, 0); run("R2");
    set_in(0, 0, 'b1010, 'b1010, 0, 0, 0, 0, 0); run("R2");
    set_in(0, 0, 'b1111, 'b0000, 0, 0, 0, 0, 0); run("R10");
    // R4: write wins over result flags.
    set_in(1, 'h0A5, 'b1111, 'b1111, 0, 0, 0, 0, 0); run("R4");
    set_in(1, 'h000, 'b1111, 'b1111, 0, 0, 0, 0, 0); run("R4");

    // R5: level 3, enabled, sweep priorities.
    set_in(1, 'h340, 0, 0, 0, 0, 0, 0, 0); run("R3");
    for (int p = 0; p < 8; p++) begin
      set_in(0, 0, 0, 0, 0, 0, 0, 1, p); run("R5");
    end
    set_in(0, 0, 0, 0, 0, 0, 0, 0, 7); run("R5");
    // R5: disabled blocks even top priority.
    set_in(1, 'h300, 0, 0, 0, 0, 0, 0, 0); run("R3");
    set_in(0, 0, 0, 0, 0, 0, 0, 1, 7); run("R5");
    // R5: level 0, priority 1 is accepted, 0 is not.
    set_in(1, 'h040, 0, 0, 0, 0, 0, 0, 0); run("R3");
    set_in(0, 0, 0, 0, 0, 0, 0, 1, 1); run("R5");
    set_in(0, 0, 0, 0, 0, 0, 0, 1, 0); run("R5");

    // R6: hardware acknowledge.
    set_in(1, 'h7DD, 0, 0, 0, 0, 0, 0, 0); run("R3");
    set_in(0, 0, 0, 0, 1, 0, 0, 1, 7); run("R6");
    // R7: software interrupt numbers around the boundary.
    set_in(1, 'h0D0, 0, 0, 0, 0, 0, 0, 0); run("R3");
    set_in(0, 0, 0, 0, 0, 1, 5, 0, 0); run("R7");
    set_in(1, 'h0D0, 0, 0, 0, 0, 0, 0, 0); run("R3");
    set_in(0, 0, 0, 0, 0, 1, 31, 0, 0); run("R7");
    set_in(1, 'h0D0, 0, 0, 0, 0, 0, 0, 0); run("R3");
    set_in(0, 0, 0, 0, 0, 1, 32, 0, 0); run("R7");
    set_in(1, 'h0D0, 0, 0, 0, 0, 0, 0, 0); run("R3");
    set_in(0, 0, 0, 0, 0, 1, 63, 0, 0); run("R7");
    // R8: acknowledge clears override a same-cycle write.
    set_in(1, 'h3C4, 0, 0, 1, 0, 0, 0, 0); run("R8");
    set_in(1, 'h3C4, 0, 0, 0, 1, 40, 0, 0); run("R8");
    set_in(1, 'h3C4, 'b1111, 'b1111, 0, 1, 2, 0, 0); run("R8");

    // R10: idle cycles hold the word.
    set_in(1, 'h6FD, 0, 0, 0, 0, 0, 0, 0); run("R3");
    idle();
    for (int i = 0; i < 4; i++) run("R10");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule